// File: doc/BRIEF.md
# CAN Controller Control and Status Bits

This block holds the handful of control and status bits of a CAN protocol controller whose values are moved by protocol events rather than only by software. A separate bit-level engine delivers one-cycle strobes: start of frame in a frame this node is sending, first bit of an error flag, arbitration loss, bus-off entry, the first and second interframe-space bit positions (with the sampled bus level), and reception of a valid frame. A CPU write port updates the operating mode and the software-controlled bits. A read port shows the mode and the bits.

The block keeps four bits: transmit-busy status, valid-receive flag, retry-after-arbitration-loss enable for single-shot operation, and an error-counter clear request. It drives a one-cycle clear pulse to the error counters and error information registers. It also drives a retransmit-permit level that the transmit scheduler uses after an arbitration loss. Writes to the clear request are accepted only while the controller is in initialization mode. Sleep and stop modes make that bit read-only.

All pins are plain control and status levels or strobes. There is no streaming interface, so no back-pressure applies.

Top module: `can_ctrl_status`

## Requirements
- R1: After reset the mode reads initialization (code 0), and transmit-busy, valid-receive, retry-enable, clear-request and the clear pulse are all 0.
- R2: A start-of-frame strobe with no clearing event in the same cycle sets transmit-busy (read bit 2) on the next cycle.
- R3: Transmit-busy is cleared on the next cycle by arbitration loss, by the first error-flag bit, by bus-off entry, or by the second interframe-space bit when the bus is recessive. A clearing event wins over a same-cycle start of frame. The second interframe-space bit with a dominant bus has no effect.
- R4: The first interframe-space bit clears transmit-busy when the mode is initialization, or when this cycle's write moves the mode to initialization.
- R5: A valid-frame strobe sets valid-receive (read bit 3). Writing 1 to the clear-valid field (write bit 5) clears it. If both happen in the same cycle, the bit ends up 1.
- R6: The retry-enable bit (read bit 4) is loaded from write bit 3 when write bit 4 is 1. retx_permit_o is 1 when single_shot_i is 0 or when retry-enable is 1, and 0 otherwise.
- R7: Writing 1 to the clear-request field (write bit 6) sets the clear request (read bit 5) only if the mode before the write is initialization (code 0). This also applies in the same write that changes the mode to operating. In operating (1), sleep (2) and stop (3) the write is ignored.
- R8: One cycle after the clear request reads 1, err_clr_o is high for exactly one cycle. In the cycle after that pulse the clear request reads 0.
- R9: When write bit 2 is 1, the mode (read and write bits 1:0) takes the value of write bits 1:0 on the next cycle. Otherwise the mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_sof_i | input | 1 | Start of frame seen in a frame this node transmits |
| ev_arb_lost_i | input | 1 | Arbitration lost during transmission |
| ev_err_flag_i | input | 1 | First bit of an error flag during a transmitted frame |
| ev_bus_off_i | input | 1 | Entry into bus-off |
| ev_ifs1_i | input | 1 | First bit of interframe space |
| ev_ifs2_i | input | 1 | Second bit of interframe space |
| bus_recessive_i | input | 1 | Sampled bus level is recessive |
| ev_valid_rx_i | input | 1 | Valid frame received |
| single_shot_i | input | 1 | Controller runs in single-shot transmit mode |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | DATA_W | CPU write data (fields per R5 to R9) |
| rd_data_o | output | DATA_W | Read value: mode[1:0], busy[2], valid[3], retry[4], clear request[5] |
| err_clr_o | output | 1 | One-cycle clear pulse to error counters and error info |
| retx_permit_o | output | 1 | Retransmission after arbitration loss allowed |

## Verification
The hardest case to reach is a clear request accepted in the same write that leaves initialization mode. In that case the gate must look at the mode held before the write, not the new one. A second hard case is the first interframe-space bit arriving in the exact cycle that software moves the mode back to initialization. Random stimulus weights writes toward initialization mode and fires event strobes sparsely, so both coincidences happen repeatedly. Directed steps also force each of them once, together with the same-cycle set/clear collisions on the valid and busy bits.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    MODE_INIT  = 2'd0,
    MODE_OPER  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_STOP  = 2'd3
  } ccs_mode_e;

  localparam int MODE_W     = 2;
  // write field positions
  localparam int WF_MODE    = 0;
  localparam int WF_MODE_WE = 2;
  localparam int WF_RETRY   = 3;
  localparam int WF_RETRY_WE= 4;
  localparam int WF_CLRV    = 5;
  localparam int WF_ECLR    = 6;
  // read field positions
  localparam int RF_MODE    = 0;
  localparam int RF_BUSY    = 2;
  localparam int RF_VALID   = 3;
  localparam int RF_RETRY   = 4;
  localparam int RF_ECLR    = 5;
  localparam int MIN_DATA_W = 7;
endpackage

// File: rtl/ccs_mode_reg.sv
module ccs_mode_reg
  import ccs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      mode_we,
  input  ccs_mode_e mode_wdata,
  output ccs_mode_e mode_q,
  output ccs_mode_e mode_nxt
);
  always_comb begin
    mode_nxt = mode_q;
    if (wr_en && mode_we) mode_nxt = mode_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_INIT;
    else        mode_q <= mode_nxt;
  end
endmodule

// File: rtl/ccs_tx_status.sv
module ccs_tx_status
  import ccs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_sof,
  input  logic      ev_arb_lost,
  input  logic      ev_err_flag,
  input  logic      ev_bus_off,
  input  logic      ev_ifs1,
  input  logic      ev_ifs2,
  input  logic      bus_recessive,
  input  ccs_mode_e mode_nxt,
  output logic      busy_q
);
  logic ifs_exit;
  logic to_init;
  logic drop;

  assign to_init  = ev_ifs1 && (mode_nxt == MODE_INIT);
  assign ifs_exit = ev_ifs2 && bus_recessive;
  assign drop     = ev_arb_lost | ev_err_flag | ev_bus_off | ifs_exit | to_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (drop)   busy_q <= 1'b0;
    else if (ev_sof) busy_q <= 1'b1;
  end
endmodule

// File: rtl/ccs_sw_flags.sv
module ccs_sw_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_valid_rx,
  input  logic clr_valid_wr,
  input  logic retry_wr,
  input  logic retry_wdata,
  output logic valid_q,
  output logic retry_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      if (ev_valid_rx)       valid_q <= 1'b1;
      else if (clr_valid_wr) valid_q <= 1'b0;
      if (retry_wr)          retry_q <= retry_wdata;
    end
  end
endmodule

// File: rtl/ccs_errclr_seq.sv
module ccs_errclr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic req_q,
  output logic pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      req_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (req_q) begin
      pulse_q <= 1'b1;
    end else if (set_req) begin
      req_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/can_ctrl_status.sv
module can_ctrl_status
  import ccs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_sof_i,
  input  logic              ev_arb_lost_i,
  input  logic              ev_err_flag_i,
  input  logic              ev_bus_off_i,
  input  logic              ev_ifs1_i,
  input  logic              ev_ifs2_i,
  input  logic              bus_recessive_i,
  input  logic              ev_valid_rx_i,
  input  logic              single_shot_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_clr_o,
  output logic              retx_permit_o
);
  localparam int PAD_W = DATA_W - MIN_DATA_W + 1;

  ccs_mode_e mode_q, mode_nxt;
  logic busy_q, valid_q, retry_q, eclr_q, eclr_set;

  ccs_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i),
    .mode_we(wr_data_i[WF_MODE_WE]),
    .mode_wdata(ccs_mode_e'(wr_data_i[WF_MODE +: MODE_W])),
    .mode_q(mode_q),
    .mode_nxt(mode_nxt)
  );

  ccs_tx_status u_tx (
    .clk(clk), .rst_n(rst_n),
    .ev_sof(ev_tx_sof_i),
    .ev_arb_lost(ev_arb_lost_i),
    .ev_err_flag(ev_err_flag_i),
    .ev_bus_off(ev_bus_off_i),
    .ev_ifs1(ev_ifs1_i),
    .ev_ifs2(ev_ifs2_i),
    .bus_recessive(bus_recessive_i),
    .mode_nxt(mode_nxt),
    .busy_q(busy_q)
  );

  ccs_sw_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_valid_rx(ev_valid_rx_i),
    .clr_valid_wr(wr_en_i && wr_data_i[WF_CLRV]),
    .retry_wr(wr_en_i && wr_data_i[WF_RETRY_WE]),
    .retry_wdata(wr_data_i[WF_RETRY]),
    .valid_q(valid_q),
    .retry_q(retry_q)
  );

  // gate uses the mode held before this write
  assign eclr_set = wr_en_i && wr_data_i[WF_ECLR] && (mode_q == MODE_INIT);

  ccs_errclr_seq u_eclr (
    .clk(clk), .rst_n(rst_n),
    .set_req(eclr_set),
    .req_q(eclr_q),
    .pulse_q(err_clr_o)
  );

  assign retx_permit_o = !single_shot_i || retry_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data_o = {{PAD_W{1'b0}}, eclr_q, retry_q, valid_q, busy_q, mode_q};
    end else begin : g_nopad
      assign rd_data_o = {eclr_q, retry_q, valid_q, busy_q, mode_q};
    end
  endgenerate
endmodule

// File: rtl/ccs_checker.sv
module ccs_checker
  import ccs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_tx_sof_i,
  input logic              ev_arb_lost_i,
  input logic              ev_err_flag_i,
  input logic              ev_bus_off_i,
  input logic              ev_ifs1_i,
  input logic              ev_ifs2_i,
  input logic              bus_recessive_i,
  input logic              ev_valid_rx_i,
  input logic              single_shot_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              err_clr_o,
  input logic              retx_permit_o
);
  logic hard_drop;
  assign hard_drop = ev_arb_lost_i | ev_err_flag_i | ev_bus_off_i |
                     (ev_ifs2_i & bus_recessive_i);

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_sof_i && !hard_drop && !ev_ifs1_i) |=> rd_data_o[RF_BUSY]);

  assert_busy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hard_drop |=> !rd_data_o[RF_BUSY]);

  assert_valid_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_rx_i |=> rd_data_o[RF_VALID]);

  assert_retx_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (single_shot_i && !rd_data_o[RF_RETRY]) |-> !retx_permit_o);

  assert_eclr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[RF_ECLR] &&
     !(wr_en_i && wr_data_i[WF_ECLR] && rd_data_o[RF_MODE +: MODE_W] == MODE_INIT))
    |=> !rd_data_o[RF_ECLR]);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_o |=> (!err_clr_o && !rd_data_o[RF_ECLR]));

  assert_pulse_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data_o[RF_ECLR]) |=> err_clr_o);
endmodule

bind can_ctrl_status ccs_checker #(.DATA_W(DATA_W)) u_ccs_checker (
  .clk(clk), .rst_n(rst_n),
  .ev_tx_sof_i(ev_tx_sof_i), .ev_arb_lost_i(ev_arb_lost_i),
  .ev_err_flag_i(ev_err_flag_i), .ev_bus_off_i(ev_bus_off_i),
  .ev_ifs1_i(ev_ifs1_i), .ev_ifs2_i(ev_ifs2_i),
  .bus_recessive_i(bus_recessive_i), .ev_valid_rx_i(ev_valid_rx_i),
  .single_shot_i(single_shot_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o), .err_clr_o(err_clr_o), .retx_permit_o(retx_permit_o)
);

// File: tb/tb_can_ctrl_status.sv
module tb_can_ctrl_status;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev = '0;
  logic ss = 1'b0;
  logic wr = 1'b0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd;
  logic eclr_p, retx;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  logic [1:0] m_mode;
  logic m_busy, m_valid, m_retry, m_req, m_pulse;

  always #10 clk = ~clk;

  can_ctrl_status #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_sof_i(ev[0]), .ev_arb_lost_i(ev[1]), .ev_err_flag_i(ev[2]),
    .ev_bus_off_i(ev[3]), .ev_ifs1_i(ev[4]), .ev_ifs2_i(ev[5]),
    .bus_recessive_i(ev[6]), .ev_valid_rx_i(ev[7]),
    .single_shot_i(ss), .wr_en_i(wr), .wr_data_i(wd),
    .rd_data_o(rd), .err_clr_o(eclr_p), .retx_permit_o(retx)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] next_mode(input logic w, input logic [DW-1:0] d, input logic [1:0] m);
    return (w && d[2]) ? d[1:0] : m;
  endfunction

  // one cycle: check current outputs, drive inputs, advance model
  task automatic step(input logic [7:0] e, input logic s, input logic w, input logic [DW-1:0] d);
    logic [1:0] nm;
    logic drop;
    @(negedge clk);
    chk("R9 mode",          {6'b0, rd[1:0]}, {6'b0, m_mode});
    chk("R2 R3 R4 busy",    {7'b0, rd[2]},   {7'b0, m_busy});
    chk("R5 valid",         {7'b0, rd[3]},   {7'b0, m_valid});
    chk("R6 retry",         {7'b0, rd[4]},   {7'b0, m_retry});
    chk("R7 R8 clear req",  {7'b0, rd[5]},   {7'b0, m_req});
    chk("R8 clear pulse",   {7'b0, eclr_p},  {7'b0, m_pulse});
    ev = e; ss = s; wr = w; wd = d;
    #1;
    chk("R6 retx permit",   {7'b0, retx},    {7'b0, (!s || m_retry)});
    nm   = next_mode(w, d, m_mode);
    drop = e[1] | e[2] | e[3] | (e[5] & e[6]) | (e[4] && nm == 2'd0);
    if (drop)      m_busy = 1'b0;
    else if (e[0]) m_busy = 1'b1;
    if (e[7])           m_valid = 1'b1;
    else if (w && d[5]) m_valid = 1'b0;
    if (w && d[4]) m_retry = d[3];
    if (m_pulse) begin m_req = 1'b0; m_pulse = 1'b0; end
    else if (m_req) m_pulse = 1'b1;
    else if (w && d[6] && m_mode == 2'd0) m_req = 1'b1;
    m_mode = nm;
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] re;
    logic [DW-1:0] rw;
    seed = 32'd2024;
    void'($urandom(seed));
    m_mode = 0; m_busy = 0; m_valid = 0; m_retry = 0; m_req = 0; m_pulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 reset rd", rd, 8'h00);
    chk("R1 reset pulse", {7'b0, eclr_p}, 8'h00);
    rst_n = 1'b1;

    // R2: start of frame sets busy
    step(8'h01, 0, 0, '0);
    // R3: ifs2 with dominant bus leaves busy set
    step(8'h20, 0, 0, '0);
    // R4: ifs1 while moving to init clears busy (write mode=0, we)
    step(8'h00, 0, 1, 8'h05);            // go to operating
    step(8'h01, 0, 0, '0);
    step(8'h10, 0, 1, 8'h04);            // ifs1 + write init
    // R3: clear wins over same-cycle start of frame
    step(8'h01, 0, 0, '0);
    step(8'h03, 0, 0, '0);
    // R5: set and clear-valid together -> stays 1
    step(8'h80, 0, 1, 8'h20);
    step(8'h00, 0, 1, 8'h20);
    // R6: retry enable and single shot
    step(8'h00, 1, 1, 8'h18);
    step(8'h00, 1, 1, 8'h10);
    // R7: clear request with leave-init in one write, then R8 sequence
    step(8'h00, 1, 1, 8'h45);
    step(8'h00, 0, 0, '0);
    step(8'h00, 0, 0, '0);
    step(8'h00, 0, 0, '0);
    // R7: ignored in sleep and stop
    step(8'h00, 0, 1, 8'h06);
    step(8'h00, 0, 1, 8'h40);
    step(8'h00, 0, 1, 8'h07);
    step(8'h00, 0, 1, 8'h40);
    step(8'h00, 0, 1, 8'h04);

    for (int i = 0; i < 3000; i++) begin
      re = '0;
      for (int b = 0; b < 8; b++) re[b] = ($urandom % 8) == 0;
      re[6] = $urandom % 2;
      rw = DW'($urandom);
      if (($urandom % 3) != 0) rw[1:0] = 2'd0;
      step(re, 1'($urandom % 2), 1'(($urandom % 3) == 0), rw);
    end
    step(8'h00, 0, 0, '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule